// File: doc/BRIEF.md
# Differential SAR conversion sequencer

This block is the digital controller of a successive-approximation converter built on two mirrored, binary-weighted capacitor arrays and a single comparator. While idle it keeps the arrays sampling: the comparator-side terminals are tied to analog ground through two sampling switches, and every bit switch connects to the analog inputs. A falling edge on the active-low start input, once acquisition has lasted long enough, begins a conversion. The sampling switches open first. One cycle later the arrays leave the inputs and go to reference ground.

A binary search then runs from the most significant bit down. For each bit, the trial word raises that element to the reference. After a fixed settling time the comparator bit decides whether the element stays there. The positive array receives the trial word and the negative array receives its bitwise inverse. When the least significant trial ends, the code is latched, busy drops and the block goes back to acquisition. The code on the output always belongs to the sample just taken. There is no pipeline latency.

Top module: `sar_seq`

## Requirements
- R1: While rst_ni is low and just after it rises: busy_o=0, samp_sw_o=1, arr_in_o=1, code_o=0, and pos_sw_o=neg_sw_o=0.
- R2: A start falling edge is accepted only after the block has spent more than ACQ_CYC cycles in acquisition. An earlier edge is ignored and busy_o stays low.
- R3: busy_o rises the cycle after an accepted edge. For that one cycle samp_sw_o=0 and arr_in_o=1. In the next cycle arr_in_o=0 and pos_sw_o=0, so all elements sit at reference ground.
- R4: Trials run MSB first. The first trial word is 1<<(WIDTH-1). Each trial lasts TRIAL_CYC cycles. A trial bit (1 = element on reference) is kept when cmp_i=1 on the trial's last cycle and cleared otherwise.
- R5: While arr_in_o=0, neg_sw_o is the bitwise inverse of pos_sw_o. While arr_in_o=1, both words are 0.
- R6: busy_o stays high for exactly WIDTH*TRIAL_CYC+2 cycles. When it falls, code_o holds the result of this conversion.
- R7: Start edges that arrive while busy_o is high have no effect on the running conversion or on what follows it.
- R8: code_o changes only when busy_o falls. It keeps the previous result throughout the next conversion.
- R9: After busy_o falls, samp_sw_o=1 and arr_in_o=1 (acquisition).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_ni | input | 1 | Conversion start, acts on its falling edge |
| cmp_i | input | 1 | Comparator result, 1 = keep trial bit |
| samp_sw_o | output | 1 | 1 = sampling switches closed to analog ground |
| arr_in_o | output | 1 | 1 = bit switches on the analog inputs |
| pos_sw_o | output | WIDTH | Positive array bit switches, 1 = reference |
| neg_sw_o | output | WIDTH | Negative array bit switches, 1 = reference |
| busy_o | output | 1 | Conversion in progress |
| code_o | output | WIDTH | Last conversion result |

## Verification
The bench builds the block with WIDTH=16, TRIAL_CYC=3 and ACQ_CYC=4. With a three-cycle trial, an off-by-one in the settling counter shows up as a wrong busy length. With a four-cycle acquisition guard, a start edge pulsed right after busy falls lands inside the guard and must be ignored. A comparator model that keeps a bit whenever the trial word does not exceed a target makes the code track the target. Targets of all zeros, all ones, a single LSB, a single MSB and a mixed pattern therefore exercise every keep and drop path of the search.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_ACQ   = 2'd0,
    PH_OPEN  = 2'd1,
    PH_HOLD  = 2'd2,
    PH_TRIAL = 2'd3
  } phase_e;
endpackage

// File: rtl/sar_trial_timer.sv
module sar_trial_timer #(
  parameter int TRIAL_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic last_o
);
  generate
    if (TRIAL_CYC <= 1) begin : g_single
      assign last_o = run_i;
    end else begin : g_count
      localparam int CW = $clog2(TRIAL_CYC);
      localparam logic [CW-1:0] LAST = CW'(TRIAL_CYC - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                      cnt_q <= '0;
        else if (!run_i || cnt_q == LAST) cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
      end

      assign last_o = run_i && (cnt_q == LAST);

      // R4: a trial never ends on consecutive cycles
      a_r4_trial_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |=> !last_o);
    end
  endgenerate
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] result_o,
  output logic             last_bit_o
);
  localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] code_q;
  logic [WIDTH-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      ptr_q  <= MSB;
    end else if (clr_i) begin
      code_q <= '0;
      ptr_q  <= MSB;
    end else if (step_i) begin
      if (cmp_i) code_q <= code_q | ptr_q;
      ptr_q <= ptr_q >> 1;
    end
  end

  assign trial_o    = code_q | ptr_q;
  assign result_o   = cmp_i ? (code_q | ptr_q) : code_q;
  assign last_bit_o = ptr_q[0];

  // R4: at most one bit under trial
  a_r4_one_trial_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ptr_q));
  // R4: decided bits only move when a trial ends
  a_r4_code_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i && !clr_i |=> $stable(code_q));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int TRIAL_CYC = 2,
  parameter int ACQ_CYC   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_ni,
  input  logic             cmp_i,
  output logic             samp_sw_o,
  output logic             arr_in_o,
  output logic [WIDTH-1:0] pos_sw_o,
  output logic [WIDTH-1:0] neg_sw_o,
  output logic             busy_o,
  output logic [WIDTH-1:0] code_o
);
  localparam int AW = $clog2(ACQ_CYC + 1) + 1;
  localparam logic [AW-1:0] ACQ_LIM = AW'(ACQ_CYC);

  phase_e           state_q;
  logic             busy_q;
  logic             start_q;
  logic [AW-1:0]    acq_cnt_q;
  logic [WIDTH-1:0] code_q;
  logic             acq_ok;
  logic             start_fall;
  logic             step;
  logic             last_bit;
  logic [WIDTH-1:0] trial;
  logic [WIDTH-1:0] result;

  assign acq_ok     = (acq_cnt_q == ACQ_LIM);
  assign start_fall = start_q && !start_ni;

  sar_trial_timer #(.TRIAL_CYC(TRIAL_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q == PH_TRIAL),
    .last_o (step)
  );

  sar_code_reg #(.WIDTH(WIDTH)) u_code (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (state_q == PH_HOLD),
    .step_i     (step),
    .cmp_i      (cmp_i),
    .trial_o    (trial),
    .result_o   (result),
    .last_bit_o (last_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b1;
    else         start_q <= start_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 acq_cnt_q <= '0;
    else if (state_q != PH_ACQ)  acq_cnt_q <= '0;
    else if (!acq_ok)            acq_cnt_q <= acq_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_ACQ;
      busy_q  <= 1'b0;
      code_q  <= '0;
    end else begin
      unique case (state_q)
        PH_ACQ: if (start_fall && acq_ok) begin
          state_q <= PH_OPEN;
          busy_q  <= 1'b1;
        end
        PH_OPEN: state_q <= PH_HOLD;
        PH_HOLD: state_q <= PH_TRIAL;
        PH_TRIAL: if (step && last_bit) begin
          state_q <= PH_ACQ;
          busy_q  <= 1'b0;
          code_q  <= result;
        end
        default: state_q <= PH_ACQ;
      endcase
    end
  end

  // sampling switches open one cycle before the arrays leave the inputs
  assign samp_sw_o = (state_q == PH_ACQ);
  assign arr_in_o  = (state_q == PH_ACQ) || (state_q == PH_OPEN);
  assign pos_sw_o  = (state_q == PH_TRIAL) ? trial : '0;
  assign neg_sw_o  = arr_in_o ? '0 : ~pos_sw_o;
  assign busy_o    = busy_q;
  assign code_o    = code_q;

  a_r3_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_ACQ && acq_ok && start_q && !start_ni) |=> busy_o);
  a_r3_open_before_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arr_in_o) |-> (!samp_sw_o && $past(!samp_sw_o)));
  a_r9_acq_on_inputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_sw_o |-> (arr_in_o && !busy_o));
  a_r8_code_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> $fell(busy_o));
  a_r7_no_early_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != PH_TRIAL) |=> busy_o);
  a_r2_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !acq_ok) |=> !busy_o);
endmodule

// File: tb/sar_seq_test.sv
module sar_seq_test;
  localparam int W  = 16;
  localparam int T  = 3;
  localparam int AC = 4;
  localparam int BUSY_LEN = W * T + 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_n = 1'b1;
  logic         cmp;
  logic         samp_sw, arr_in, busy;
  logic [W-1:0] pos_sw, neg_sw, code;
  logic [W-1:0] target = '0;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  // comparator model: keep the bit while the trial word does not exceed the target
  assign cmp = (pos_sw <= target);

  sar_seq #(.WIDTH(W), .TRIAL_CYC(T), .ACQ_CYC(AC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_ni(start_n), .cmp_i(cmp),
    .samp_sw_o(samp_sw), .arr_in_o(arr_in), .pos_sw_o(pos_sw),
    .neg_sw_o(neg_sw), .busy_o(busy), .code_o(code));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one conversion; pulse_mid drives an extra start edge while busy
  task automatic convert(input logic [W-1:0] tgt, input logic pulse_mid);
    int len;
    logic [W-1:0] prev;
    prev   = code;
    target = tgt;
    start_n = 1'b0;
    @(negedge clk);
    check("R3 busy rises", W'(busy), W'(1));
    check("R3 samp open", W'(samp_sw), W'(0));
    check("R3 still on inputs", W'(arr_in), W'(1));
    check("R5 words zero on inputs", neg_sw | pos_sw, '0);
    start_n = 1'b1;
    @(negedge clk);
    check("R3 off inputs", W'(arr_in), W'(0));
    check("R3 all at ref ground", pos_sw, '0);
    check("R5 neg inverse hold", neg_sw, ~pos_sw);
    @(negedge clk);
    check("R4 first trial msb", pos_sw, W'(1) << (W - 1));
    check("R5 neg inverse trial", neg_sw, ~pos_sw);
    check("R8 old code held", code, prev);
    len = 3;
    while (busy && len < 1000) begin
      if (pulse_mid && len == 10) start_n = 1'b0;
      if (pulse_mid && len == 12) start_n = 1'b1;
      @(negedge clk);
      if (busy) len++;
    end
    check("R6 busy length", W'(len), W'(BUSY_LEN));
    check("R6 code result", code, tgt);
    check("R9 samp closed", W'(samp_sw), W'(1));
    check("R9 on inputs", W'(arr_in), W'(1));
    check("R5 words zero after", pos_sw | neg_sw, '0);
  endtask

  task automatic t_reset;
    check("R1 busy", W'(busy), W'(0));
    check("R1 samp", W'(samp_sw), W'(1));
    check("R1 inputs", W'(arr_in), W'(1));
    check("R1 code", code, '0);
    check("R1 words", pos_sw | neg_sw, '0);
  endtask

  task automatic t_early_start;
    // edge right after busy falls lies inside the acquisition guard
    start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
    check("R2 early edge ignored", W'(busy), W'(0));
    idle(2);
    check("R2 still idle", W'(busy), W'(0));
    check("R2 still sampling", W'(samp_sw), W'(1));
    idle(AC + 2);
  endtask

  task automatic t_mid_start(input logic [W-1:0] tgt);
    convert(tgt, 1'b1);
    idle(2);
    check("R7 no restart", W'(busy), W'(0));
    check("R7 code kept", code, tgt);
    idle(AC + 2);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    idle(AC + 2);
    convert(16'hA5C3, 1'b0);
    t_early_start();
    convert(16'h0000, 1'b0);
    idle(AC + 2);
    convert(16'hFFFF, 1'b0);
    idle(AC + 2);
    convert(16'h0001, 1'b0);
    idle(AC + 2);
    t_mid_start(16'h8000);
    convert(16'h3C5A, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule